// File: doc/BRIEF.md
# Integer ALU with Carry and Condition Nibble

This block performs one 32-bit integer arithmetic or logic operation per accepted request and presents the outcome one clock later from an output register. Each request carries two register operands, a 16-bit immediate, an operation code, the current carry bit, the current summary-overflow bit, a flag saying that the first source register index is zero, and a record flag.

The block returns the 32-bit result and the updated carry bit. It also returns a 4-bit condition nibble taken from the result. The nibble is produced when the record flag is set, and always for the AND-with-upper-immediate operation. The register file and the condition register sit outside the block. The surrounding pipeline writes back whatever the block returns.

Top module: `ialu_top`

## Requirements
- R1: Outputs are registered. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result`, `ca_out` and `cr0` change only after an accepted request. A synchronous active-low reset clears every output to zero.
- R2: Op codes 0 (add immediate) and 1 (add shifted immediate) add the sign-extended immediate to `src_a`. Op 1 first moves the immediate into bits 31:16 with zeros below. For these two ops only, `ra_is_zero` high replaces `src_a` with zero. Op 13 (plain add, `src_a + src_b`) ignores `ra_is_zero`.
- R3: Op 5 returns `src_a | {imm,16'h0}` and op 6 returns `src_a & {imm,16'h0}`.
- R4: Op 2 (`src_a` + sign-extended immediate) and op 3 (`src_a + src_b`) set `ca_out` when the unsigned 32-bit sum is less than `src_a`, and clear it otherwise.
- R5: Op 4 returns `src_a + ca_in + 32'hFFFFFFFF`. Its `ca_out` is 1 when `src_a` is nonzero or `ca_in` is 1.
- R6: Op 7 returns the low 32 bits of `src_a` times the sign-extended immediate.
- R7: Op 8 returns bits 63:32 of the signed 64-bit product `src_a*src_b`. Op 9 returns the same bits of the unsigned product.
- R8: Op 10 copies bit 15 of `src_a` into bits 31:16. Op 11 returns `src_a | ~src_b`. Op 12 returns `-src_a`.
- R9: Only ops 2, 3 and 4 alter carry. Every other op returns `ca_out` equal to `ca_in`. Codes 14 and 15 return a zero result.
- R10: With `rec` set, `cr0_valid` is high together with `out_valid`. `cr0` is then {LT,GT,EQ,SO}: bit 3 set for a negative result, bit 2 for a positive nonzero result, bit 1 for a zero result, and bit 0 copied from `so_in`. When `cr0_valid` is low, `cr0` is 4'h0.
- R11: Op 6 raises `cr0_valid` and produces `cr0` even when `rec` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| ra_is_zero | input | 1 | First source register index is zero |
| ca_in | input | 1 | Current carry bit |
| so_in | input | 1 | Current summary-overflow bit |
| rec | input | 1 | Record flag: produce condition nibble |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 32 | Operation result |
| ca_out | output | 1 | Updated carry bit |
| cr0_valid | output | 1 | Condition nibble produced |
| cr0 | output | 4 | Condition nibble {LT,GT,EQ,SO} |

## Verification
Immediates are tried with bit 15 clear and set. This separates sign extension from zero extension, and shows whether the shifted forms keep the lower half zero. The add-immediate ops run with `ra_is_zero` both low and high, and the plain add runs with it high, to show that the zero substitution is confined to the immediate forms. Carry ops run at the wrap point and just below it, and the minus-one add runs on all four corners of zero/nonzero operand and carry. The high multiplies use an all-ones operand to tell signed from unsigned handling. Results are chosen to be negative, positive and zero, with and without the record flag and summary overflow, to cover each nibble bit.

// File: rtl/ialu_pkg.sv
// Package: operation codes and widths shared by the integer ALU blocks.
package ialu_pkg;
    localparam int DATA_W = 32;
    localparam int IMM_W  = 16;
    localparam int OP_W   = 4;
    localparam int CR_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADDI   = 4'd0,
        OP_ADDIS  = 4'd1,
        OP_ADDIC  = 4'd2,
        OP_ADDC   = 4'd3,
        OP_ADDME  = 4'd4,
        OP_ORIS   = 4'd5,
        OP_ANDIS  = 4'd6,
        OP_MULLI  = 4'd7,
        OP_MULHW  = 4'd8,
        OP_MULHWU = 4'd9,
        OP_EXTSH  = 4'd10,
        OP_ORC    = 4'd11,
        OP_NEG    = 4'd12,
        OP_ADD    = 4'd13
    } alu_op_e;
endpackage

// File: rtl/ialu_operands.sv
// Module: forms the immediate variants and the first operand.
// Assumes IMM_W <= W. The zero substitution of the first operand is
// applied only for the two add-immediate forms.
module ialu_operands #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [3:0]       op,
    input  logic [W-1:0]     src_a,
    input  logic [IMM_W-1:0] imm,
    input  logic             ra_is_zero,
    output logic [W-1:0]     opa,
    output logic [W-1:0]     imm_sext,
    output logic [W-1:0]     imm_shift
);
    import ialu_pkg::*;
    localparam int PAD_W = W - IMM_W;

    // Immediate forms: sign-extended low, and placed at the top with zeros below.
    always_comb begin
        imm_sext  = {{PAD_W{imm[IMM_W-1]}}, imm};
        imm_shift = {imm, {PAD_W{1'b0}}};
    end

    // First operand: literal zero for add-immediate forms with index zero.
    always_comb begin
        if (ra_is_zero && (op == OP_ADDI || op == OP_ADDIS))
            opa = '0;
        else
            opa = src_a;
    end
endmodule

// File: rtl/ialu_arith.sv
// Module: adders, negate and multipliers with carry generation.
// Assumes the caller passes the already-selected first operand.
// Carry write is flagged only for the three carry-producing ops.
module ialu_arith #(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] src_b,
    input  logic [W-1:0] imm_sext,
    input  logic [W-1:0] imm_shift,
    input  logic         ca_in,
    output logic [W-1:0] res,
    output logic         hit,
    output logic         carry,
    output logic         carry_we
);
    import ialu_pkg::*;
    localparam int PW = 2 * W + 2;

    logic [W-1:0]  addend;
    logic [W:0]    sum;
    logic [W:0]    sum_me;
    logic          mul_signed;
    logic [W:0]    ext_a;
    logic [W:0]    ext_b;
    logic [PW-1:0] prod;
    logic [W-1:0]  prod_lo;

    // Second addend chosen by op for the shared adder.
    always_comb begin
        case (op)
            OP_ADDI, OP_ADDIC: addend = imm_sext;
            OP_ADDIS:          addend = imm_shift;
            default:           addend = src_b;
        endcase
    end

    // Shared adder and the minus-one-extended adder.
    always_comb begin
        sum    = {1'b0, opa} + {1'b0, addend};
        sum_me = {1'b0, opa} + {1'b0, {W{1'b1}}} + {{W{1'b0}}, ca_in};
    end

    // One extended multiplier serves both signed and unsigned high products.
    always_comb begin
        mul_signed = (op == OP_MULHW);
        ext_a      = {mul_signed & opa[W-1], opa};
        ext_b      = {mul_signed & src_b[W-1], src_b};
        prod       = PW'($signed({{(W+1){ext_a[W]}}, ext_a}) *
                         $signed({{(W+1){ext_b[W]}}, ext_b}));
        prod_lo    = opa * imm_sext;
    end

    // Result, carry and hit selection.
    always_comb begin
        res      = '0;
        hit      = 1'b1;
        carry    = 1'b0;
        carry_we = 1'b0;
        case (op)
            OP_ADDI, OP_ADDIS, OP_ADD: res = sum[W-1:0];
            OP_ADDIC, OP_ADDC: begin
                res      = sum[W-1:0];
                carry    = sum[W];
                carry_we = 1'b1;
            end
            OP_ADDME: begin
                res      = sum_me[W-1:0];
                carry    = sum_me[W];
                carry_we = 1'b1;
            end
            OP_MULLI:          res = prod_lo;
            OP_MULHW, OP_MULHWU: res = prod[2*W-1:W];
            OP_NEG:            res = ~opa + 1'b1;
            default:           hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ialu_logic.sv
// Module: bitwise ops with the shifted immediate, OR-complement and halfword sign extension.
// Assumes W >= 16.
module ialu_logic #(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic [W-1:0] imm_shift,
    output logic [W-1:0] res,
    output logic         hit
);
    import ialu_pkg::*;
    localparam int HW = 16;

    // Logic result selection.
    always_comb begin
        res = '0;
        hit = 1'b1;
        case (op)
            OP_ORIS:  res = src_a | imm_shift;
            OP_ANDIS: res = src_a & imm_shift;
            OP_ORC:   res = src_a | ~src_b;
            OP_EXTSH: res = {{(W-HW){src_a[HW-1]}}, src_a[HW-1:0]};
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ialu_cr0.sv
// Module: derives the {LT,GT,EQ,SO} nibble from a result.
// Assumes the result is read as two's complement.
module ialu_cr0 #(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    input  logic         so_in,
    output logic [3:0]   nib
);
    // Sign and zero classification.
    always_comb begin
        nib[3] = res[W-1];
        nib[1] = (res == '0);
        nib[2] = !res[W-1] && (res != '0);
        nib[0] = so_in;
    end
endmodule

// File: rtl/ialu_top.sv
// Module: top of the integer ALU; selects the unit result and registers outputs.
// Assumes one request per cycle with no back-pressure; latency is one cycle.
module ialu_top #(
    parameter int W     = ialu_pkg::DATA_W,
    parameter int IMM_W = ialu_pkg::IMM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic [W-1:0]     src_a,
    input  logic [W-1:0]     src_b,
    input  logic [IMM_W-1:0] imm,
    input  logic             ra_is_zero,
    input  logic             ca_in,
    input  logic             so_in,
    input  logic             rec,
    output logic             out_valid,
    output logic [W-1:0]     result,
    output logic             ca_out,
    output logic             cr0_valid,
    output logic [3:0]       cr0
);
    import ialu_pkg::*;

    logic [W-1:0] opa, imm_sext, imm_shift;
    logic [W-1:0] ar_res, lg_res, nx_res;
    logic         ar_hit, lg_hit, ar_c, ar_cwe;
    logic [3:0]   nx_nib;
    logic         nx_upd;

    ialu_operands #(.W(W), .IMM_W(IMM_W)) u_opnd (
        .op(op), .src_a(src_a), .imm(imm), .ra_is_zero(ra_is_zero),
        .opa(opa), .imm_sext(imm_sext), .imm_shift(imm_shift)
    );

    ialu_arith #(.W(W)) u_arith (
        .op(op), .opa(opa), .src_b(src_b), .imm_sext(imm_sext),
        .imm_shift(imm_shift), .ca_in(ca_in), .res(ar_res), .hit(ar_hit),
        .carry(ar_c), .carry_we(ar_cwe)
    );

    ialu_logic #(.W(W)) u_logic (
        .op(op), .src_a(src_a), .src_b(src_b), .imm_shift(imm_shift),
        .res(lg_res), .hit(lg_hit)
    );

    // Merge unit results; unknown codes give zero.
    always_comb begin
        if (ar_hit)      nx_res = ar_res;
        else if (lg_hit) nx_res = lg_res;
        else             nx_res = '0;
        nx_upd = rec || (op == OP_ANDIS);
    end

    ialu_cr0 #(.W(W)) u_cr0 (.res(nx_res), .so_in(so_in), .nib(nx_nib));

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ca_out    <= 1'b0;
            cr0_valid <= 1'b0;
            cr0       <= '0;
        end else begin
            out_valid <= in_valid;
            cr0_valid <= in_valid && nx_upd;
            if (in_valid) begin
                result <= nx_res;
                ca_out <= ar_cwe ? ar_c : ca_in;
                cr0    <= nx_upd ? nx_nib : 4'h0;
            end
        end
    end
endmodule

// File: rtl/ialu_checker.sv
// Module: temporal checks on the ALU ports, bound into ialu_top.
module ialu_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [3:0]   op,
    input logic         ca_in,
    input logic         rec,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         ca_out,
    input logic         cr0_valid,
    input logic [3:0]   cr0
);
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> ($stable(result) && $stable(ca_out)));

    p_carry_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 4'd2 && op != 4'd3 && op != 4'd4) |=> ca_out == $past(ca_in));

    p_nib_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_valid |-> ($countones(cr0[3:1]) == 1 && cr0[3] == result[W-1]
                       && cr0[1] == (result == '0)));

    p_nib_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cr0_valid |-> cr0 == 4'h0 || !out_valid);

    p_andis_rec_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (rec || op == 4'd6)) |=> cr0_valid);
endmodule

bind ialu_top ialu_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .ca_in(ca_in),
    .rec(rec), .out_valid(out_valid), .result(result), .ca_out(ca_out),
    .cr0_valid(cr0_valid), .cr0(cr0)
);

// File: tb/ialu_top_tb.sv
// Directed bench for ialu_top: one task per scenario.
module ialu_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [15:0] imm = '0;
    logic        ra_is_zero = 1'b0, ca_in = 1'b0, so_in = 1'b0, rec = 1'b0;
    logic        out_valid, ca_out, cr0_valid;
    logic [31:0] result;
    logic [3:0]  cr0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ialu_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src_a(src_a),
        .src_b(src_b), .imm(imm), .ra_is_zero(ra_is_zero), .ca_in(ca_in),
        .so_in(so_in), .rec(rec), .out_valid(out_valid), .result(result),
        .ca_out(ca_out), .cr0_valid(cr0_valid), .cr0(cr0)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge, sample the registered outputs one cycle later.
    task automatic issue(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] i, input logic z, input logic c,
                         input logic s, input logic r);
        @(negedge clk);
        op = o; src_a = a; src_b = b; imm = i; ra_is_zero = z; ca_in = c;
        so_in = s; rec = r; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_rc(input string req, input logic [31:0] er, input logic ec);
        chk({req, " result"}, result, er);
        chk({req, " carry"}, {31'd0, ca_out}, {31'd0, ec});
        chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
    endtask

    task automatic t_reset_r1();
        chk("R1 reset result", result, 32'd0);
        chk("R1 reset flags", {27'd0, out_valid, ca_out, cr0_valid, 2'd0} | {28'd0, cr0}, 32'd0);
    endtask

    task automatic t_addimm_r2();
        issue(4'd0, 32'h0000_0100, 0, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_rc("R2 addi sext", 32'h0000_00FF, 1'b1);
        issue(4'd0, 32'h1234_5678, 0, 16'h0005, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_rc("R2 addi zero-index", 32'h0000_0005, 1'b0);
        issue(4'd1, 32'h0000_0010, 0, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_rc("R2 addis", 32'h8000_0010, 1'b0);
        issue(4'd13, 32'h0000_0003, 32'h4, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_rc("R2 add ignores zero-index", 32'h0000_0007, 1'b0);
    endtask

    task automatic t_shift_logic_r3();
        issue(4'd5, 32'h0000_00F0, 0, 16'hA5A5, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_rc("R3 oris", 32'hA5A5_00F0, 1'b0);
        issue(4'd6, 32'hFFFF_FFFF, 0, 16'h00F0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_rc("R3 andis", 32'h00F0_0000, 1'b0);
    endtask

    task automatic t_carry_r4();
        issue(4'd2, 32'hFFFF_FFFF, 0, 16'h0001, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_rc("R4 addic wrap", 32'h0000_0000, 1'b1);
        issue(4'd2, 32'h0000_0005, 0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_rc("R4 addic minus", 32'h0000_0004, 1'b1);
        issue(4'd3, 32'hFFFF_FFFE, 32'h1, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_rc("R4 addc no wrap", 32'hFFFF_FFFF, 1'b0);
        issue(4'd3, 32'h8000_0000, 32'h8000_0001, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_rc("R4 addc wrap", 32'h0000_0001, 1'b1);
    endtask

    task automatic t_addme_r5();
        issue(4'd4, 32'h0, 0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_rc("R5 addme a0 c0", 32'hFFFF_FFFF, 1'b0);
        issue(4'd4, 32'h0, 0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_rc("R5 addme a0 c1", 32'h0000_0000, 1'b1);
        issue(4'd4, 32'h10, 0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_rc("R5 addme a16 c0", 32'h0000_000F, 1'b1);
        issue(4'd4, 32'h10, 0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_rc("R5 addme a16 c1", 32'h0000_0010, 1'b1);
    endtask

    task automatic t_mul_r6_r7();
        issue(4'd7, 32'h0000_0003, 0, 16'hFFFE, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_rc("R6 mulli", 32'hFFFF_FFFA, 1'b0);
        issue(4'd8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_rc("R7 mulhw", 32'h0000_0000, 1'b0);
        issue(4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_rc("R7 mulhwu", 32'hFFFF_FFFE, 1'b0);
        issue(4'd8, 32'hFFFF_FFFF, 32'h0000_0002, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_rc("R7 mulhw neg", 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_misc_r8_r9();
        issue(4'd10, 32'h1234_8001, 0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_rc("R8 extsh neg", 32'hFFFF_8001, 1'b0);
        issue(4'd10, 32'hFFFF_7001, 0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_rc("R8 extsh pos", 32'h0000_7001, 1'b0);
        issue(4'd11, 32'h0000_000F, 32'hFFFF_00FF, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_rc("R8 orc", 32'h0000_FF0F, 1'b0);
        issue(4'd12, 32'h0000_0001, 0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_rc("R8 neg R9 carry kept", 32'hFFFF_FFFF, 1'b1);
        issue(4'd14, 32'h1234_5678, 32'h9, 16'h7, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_rc("R9 reserved", 32'h0000_0000, 1'b1);
    endtask

    task automatic t_cr0_r10_r11();
        issue(4'd13, 32'hFFFF_FFF0, 32'h1, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R10 neg so", {28'd0, cr0}, 32'h9);
        chk("R10 valid", {31'd0, cr0_valid}, 32'd1);
        issue(4'd13, 32'h5, 32'h1, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 pos", {28'd0, cr0}, 32'h4);
        issue(4'd12, 32'h0, 0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 zero", {28'd0, cr0}, 32'h2);
        issue(4'd13, 32'h5, 32'h1, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10 no rec nibble", {27'd0, cr0_valid, cr0}, 32'h0);
        issue(4'd6, 32'h8000_0000, 0, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11 andis forced nibble", {27'd0, cr0_valid, cr0}, 32'h18);
        issue(4'd6, 32'h0000_FFFF, 0, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R11 andis zero", {27'd0, cr0_valid, cr0}, 32'h13);
    endtask

    task automatic t_idle_r1();
        @(negedge clk);
        chk("R1 valid drops", {31'd0, out_valid}, 32'd0);
        src_a = 32'hDEAD_BEEF; op = 4'd13;
        @(negedge clk);
        chk("R1 hold result", result, 32'h0000_0002 & 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r1();
        rst_n = 1'b1;
        t_addimm_r2();
        t_shift_logic_r3();
        t_carry_r4();
        t_addme_r5();
        t_mul_r6_r7();
        t_misc_r8_r9();
        t_cr0_r10_r11();
        t_idle_r1();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule